// File: doc/BRIEF.md
# Floating-Point Status and Exception Register

This block keeps the status and control word that sits beside a floating-point datapath. It holds a two-bit rounding selector, a flush-to-zero control bit, and three five-bit exception groups: per-operation cause bits, sticky flags and trap enables. Software replaces the word through a plain write port, and any bit that is not writable is dropped on the way in. The rounding choice and the flush control are decoded and driven straight back to the arithmetic units.

When an arithmetic operation completes, the datapath offers its raw exception vector on a valid/ready channel. A transfer takes place on a rising edge where `upd_valid` and `upd_ready` are both high. The datapath must hold `upd_valid`, `upd_exc` and `upd_approx` steady until that transfer happens. The block lowers `upd_ready` in any cycle in which software writes the word, so the write takes effect first and the update waits one cycle instead of being lost. On each accepted update the cause group is rebuilt from the new vector alone and ORed into the sticky flags. If any new cause bit is also enabled, a trap request pulses for one cycle with code 0x120.

Bit layout of the word: rounding selector 1:0, flags 6:2, enables 11:7, cause 16:12, bit 17 reserved (reads 0), flush control 18. Within each exception group and on `upd_exc`, the bit order from high to low is invalid (4), divide-by-zero (3), overflow (2), underflow (1), inexact (0).

Top module: `fpsr_core`

## Requirements
- R1: While reset is held and on the first cycle after it, `csr_q` is 0, `trap_req` is 0, `rnd_to_zero` is 0 and `flush_zero` is 0.
- R2: A write stores `wr_data` ANDed with the writable mask. The mask covers every bit except the reserved bit 17, which always reads 0.
- R3: `rnd_to_zero` is 1 exactly when the rounding selector (bits 1:0) holds 2'b01. Every other encoding gives 0, which means round to nearest even.
- R4: `flush_zero` follows bit 18 of the word.
- R5: An accepted update replaces the whole cause field (bits 16:12) with the new exception vector, so causes from earlier operations are cleared.
- R6: An accepted update ORs the new exception vector into the flag field (bits 6:2), and flags that are already set stay set.
- R7: If the new cause bits ANDed with the enables (bits 11:7) are nonzero, `trap_req` is high for exactly the cycle after the update, with `trap_code` equal to 12'h120.
- R8: An update with `upd_approx` high and an all-zero `upd_exc` records inexact (cause and flag bit 0). With any other exception present, `upd_exc` is recorded unchanged.
- R9: `upd_ready` is low whenever `wr_en` is high. In that cycle the write wins and the update is taken on a later cycle.
- R10: An update whose exceptions are all disabled produces no trap request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 19 | Software write value |
| upd_valid | input | 1 | Exception update offered |
| upd_ready | output | 1 | Update can be accepted this cycle |
| upd_exc | input | 5 | Raw exception vector {V,Z,O,U,I} |
| upd_approx | input | 1 | Update comes from the approximate reciprocal square root |
| csr_q | output | 19 | Current status and control word |
| rnd_to_zero | output | 1 | 1: round toward zero, 0: round to nearest even |
| flush_zero | output | 1 | Flush-to-zero enable for the datapath |
| trap_req | output | 1 | One-cycle trap request |
| trap_code | output | 12 | Exception code, 12'h120 while trap_req is high |

## Verification
The assertions check the following on every cycle:
- the reserved bit reads 0;
- flags never drop except by a write;
- a write lands masked on the next cycle;
- `upd_ready` is low during a write;
- a trap always follows an accepted update, carries the fixed code and matches an enabled cause;
- the approximate-operation inexact rule holds.

Only the bench's scenarios can show the exact cause replacement after a sequence of differing updates, the accumulation of flags across several operations, and the decode of every rounding encoding. They also show that a colliding update is applied on the cycle after the write, on top of the freshly written word.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int NEXC      = 5;
  localparam int RM_W      = 2;
  localparam int RM_LSB    = 0;
  localparam int FLAG_LSB  = RM_LSB + RM_W;
  localparam int EN_LSB    = FLAG_LSB + NEXC;
  localparam int CAUSE_LSB = EN_LSB + NEXC;
  localparam int RSVD_BIT  = CAUSE_LSB + NEXC;
  localparam int FLUSH_BIT = RSVD_BIT + 1;
  localparam int CSR_W     = FLUSH_BIT + 1;
  localparam int CODE_W    = 12;

  localparam logic [CSR_W-1:0] WR_MASK  = ~(CSR_W'(1) << RSVD_BIT);
  localparam logic [RM_W-1:0]  RM_TOZERO = 2'b01;
  localparam logic [CODE_W-1:0] TRAP_CODE = 12'h120;

  typedef enum logic [2:0] {
    EXC_INEXACT = 3'd0,
    EXC_UNDER   = 3'd1,
    EXC_OVER    = 3'd2,
    EXC_DIVZ    = 3'd3,
    EXC_INVALID = 3'd4
  } exc_idx_e;
endpackage

// File: rtl/fpsr_exc_shape.sv
module fpsr_exc_shape
  import fpsr_pkg::*;
(
  input  logic [NEXC-1:0] raw_exc,
  input  logic            approx,
  output logic [NEXC-1:0] eff_exc
);
  always_comb begin
    eff_exc = raw_exc;
    if (approx && (raw_exc == '0))
      eff_exc[EXC_INEXACT] = 1'b1;
  end
endmodule

// File: rtl/fpsr_trap_eval.sv
module fpsr_trap_eval #(
  parameter int N = 5
) (
  input  logic [N-1:0] cause,
  input  logic [N-1:0] enable,
  output logic         hit
);
  logic [N-1:0] armed;
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign armed[i] = cause[i] & enable[i];
  end
  assign hit = |armed;
endmodule

// File: rtl/fpsr_mode_dec.sv
module fpsr_mode_dec
  import fpsr_pkg::*;
(
  input  logic [CSR_W-1:0] word,
  output logic             to_zero,
  output logic             flush
);
  assign to_zero = (word[RM_LSB +: RM_W] == RM_TOZERO);
  assign flush   = word[FLUSH_BIT];
endmodule

// File: rtl/fpsr_core.sv
module fpsr_core
  import fpsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CSR_W-1:0]  wr_data,
  input  logic              upd_valid,
  output logic              upd_ready,
  input  logic [NEXC-1:0]   upd_exc,
  input  logic              upd_approx,
  output logic [CSR_W-1:0]  csr_q,
  output logic              rnd_to_zero,
  output logic              flush_zero,
  output logic              trap_req,
  output logic [CODE_W-1:0] trap_code
);
  logic [CSR_W-1:0] csr_r, csr_nx;
  logic [NEXC-1:0]  new_cause;
  logic             hit;
  logic             take_upd;
  logic             trap_r;

  assign upd_ready = ~wr_en;
  assign take_upd  = upd_valid & upd_ready;

  fpsr_exc_shape u_shape (
    .raw_exc (upd_exc),
    .approx  (upd_approx),
    .eff_exc (new_cause)
  );

  fpsr_trap_eval #(.N(NEXC)) u_trap (
    .cause  (new_cause),
    .enable (csr_r[EN_LSB +: NEXC]),
    .hit    (hit)
  );

  always_comb begin
    csr_nx = csr_r;
    if (wr_en) begin
      csr_nx = wr_data & WR_MASK;
    end else if (take_upd) begin
      csr_nx[CAUSE_LSB +: NEXC] = new_cause;
      csr_nx[FLAG_LSB +: NEXC]  = csr_r[FLAG_LSB +: NEXC] | new_cause;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csr_r  <= '0;
      trap_r <= 1'b0;
    end else begin
      csr_r  <= csr_nx;
      trap_r <= take_upd & hit;
    end
  end

  fpsr_mode_dec u_mode (
    .word    (csr_r),
    .to_zero (rnd_to_zero),
    .flush   (flush_zero)
  );

  assign csr_q     = csr_r;
  assign trap_req  = trap_r;
  assign trap_code = trap_r ? TRAP_CODE : '0;
endmodule

// File: rtl/fpsr_core_chk.sv
module fpsr_core_chk
  import fpsr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [CSR_W-1:0]  wr_data,
  input logic              upd_valid,
  input logic              upd_ready,
  input logic [NEXC-1:0]   upd_exc,
  input logic              upd_approx,
  input logic [CSR_W-1:0]  csr_q,
  input logic              trap_req,
  input logic [CODE_W-1:0] trap_code
);
  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    csr_q[RSVD_BIT] == 1'b0);

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> csr_q == ($past(wr_data) & WR_MASK));

  assert_flags_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> ((csr_q[FLAG_LSB +: NEXC] & $past(csr_q[FLAG_LSB +: NEXC]))
                       == $past(csr_q[FLAG_LSB +: NEXC])));

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !upd_ready);

  assert_trap_after_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $past(upd_valid && upd_ready));

  assert_trap_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> trap_code == TRAP_CODE);

  assert_trap_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> ((csr_q[CAUSE_LSB +: NEXC] & csr_q[EN_LSB +: NEXC]) != '0));

  assert_approx_inexact_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_ready && upd_approx && upd_exc == '0)
      |=> csr_q[CAUSE_LSB +: NEXC] == NEXC'(1));
endmodule

bind fpsr_core fpsr_core_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .upd_valid  (upd_valid),
  .upd_ready  (upd_ready),
  .upd_exc    (upd_exc),
  .upd_approx (upd_approx),
  .csr_q      (csr_q),
  .trap_req   (trap_req),
  .trap_code  (trap_code)
);

// File: tb/fpsr_core_test.sv
module fpsr_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [18:0] wr_data = '0;
  logic        upd_valid = 1'b0;
  logic        upd_ready;
  logic [4:0]  upd_exc = '0;
  logic        upd_approx = 1'b0;
  logic [18:0] csr_q;
  logic        rnd_to_zero, flush_zero, trap_req;
  logic [11:0] trap_code;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [18:0] csr;
    logic        trap;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  logic [18:0] model = '0;
  logic        xfer = 1'b0;

  always #5 clk = ~clk;

  fpsr_core uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_exc(upd_exc),
    .upd_approx(upd_approx), .csr_q(csr_q), .rnd_to_zero(rnd_to_zero),
    .flush_zero(flush_zero), .trap_req(trap_req), .trap_code(trap_code)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  always @(posedge clk)
    xfer <= rst_n && (wr_en || (upd_valid && upd_ready));

  // monitor: one expected item per observed transfer
  always @(negedge clk) begin
    if (xfer) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "scoreboard-empty", 0, 1);
      end else begin
        exp_t e;
        logic exz;
        e = exp_q.pop_front();
        exz = (e.csr[1:0] == 2'b01);
        check(csr_q == e.csr, {e.tag, " csr"}, 32'(csr_q), 32'(e.csr));
        check(trap_req == e.trap, {e.tag, " trap"}, 32'(trap_req), 32'(e.trap));
        if (e.trap)
          check(trap_code == 12'h120, {e.tag, " code R7"}, 32'(trap_code), 32'h120);
        check(rnd_to_zero == exz, {e.tag, " rnd R3"}, 32'(rnd_to_zero), 32'(exz));
        check(flush_zero == e.csr[18], {e.tag, " flush R4"}, 32'(flush_zero), 32'(e.csr[18]));
      end
    end
  end

  function automatic void push_write(input logic [18:0] d, input string tag);
    exp_t e;
    model = d & 19'h5FFFF;
    e.csr = model; e.trap = 1'b0; e.tag = tag;
    exp_q.push_back(e);
  endfunction

  function automatic void push_op(input logic [4:0] ex, input logic ap, input string tag);
    exp_t e;
    logic [4:0] c;
    c = (ap && ex == 5'd0) ? 5'b00001 : ex;
    e.trap = |(c & model[11:7]);
    model[16:12] = c;
    model[6:2]   = model[6:2] | c;
    e.csr = model; e.tag = tag;
    exp_q.push_back(e);
  endfunction

  task automatic sw_write(input logic [18:0] d, input string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    push_write(d, tag);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_op(input logic [4:0] ex, input logic ap, input string tag);
    @(negedge clk);
    upd_valid = 1'b1; upd_exc = ex; upd_approx = ap;
    push_op(ex, ap, tag);
    @(negedge clk);
    upd_valid = 1'b0; upd_approx = 1'b0; upd_exc = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(csr_q == 0 && trap_req == 0 && rnd_to_zero == 0 && flush_zero == 0,
          "R1 reset", 32'(csr_q), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(csr_q == 0 && trap_req == 0, "R1 after release", 32'(csr_q), 0);

    sw_write(19'h7FFFF, "R2 mask all ones");       // bit17 dropped, rm=11 -> nearest
    sw_write(19'h00002, "R3 rm=10 nearest");
    sw_write(19'h00001, "R3 rm=01 to-zero");
    do_op(5'b10000, 1'b0, "R5 R6 R10 invalid disabled");
    do_op(5'b00001, 1'b0, "R5 cause replaced, R6 flags kept");
    sw_write(19'h40401, "R4 flush on, enable divz");
    do_op(5'b01000, 1'b0, "R7 enabled divz trap");
    @(negedge clk);
    check(trap_req == 1'b0, "R7 trap is one cycle", 32'(trap_req), 0);
    do_op(5'b00110, 1'b0, "R10 disabled over+under");
    do_op(5'b00000, 1'b1, "R8 approx alone gives inexact");
    do_op(5'b00100, 1'b1, "R8 approx with overflow");
    do_op(5'b00000, 1'b0, "R5 empty update clears cause");

    // collision: write and update offered together
    @(negedge clk);
    wr_en = 1'b1; wr_data = 19'h00F80;   // all enables on
    upd_valid = 1'b1; upd_exc = 5'b00010; upd_approx = 1'b0;
    #1;
    check(upd_ready == 1'b0, "R9 ready low during write", 32'(upd_ready), 0);
    push_write(19'h00F80, "R9 write wins");
    push_op(5'b00010, 1'b0, "R9 held update applied after write");
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    check(upd_ready == 1'b1, "R9 ready returns", 32'(upd_ready), 1);
    @(negedge clk);
    upd_valid = 1'b0; upd_exc = '0;

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "scoreboard drained", 32'(exp_q.size()), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule